// File: doc/BRIEF.md
# Error Interrupt Status Controller

This block gathers six error event pulses from a PCIe controller into sticky status bits and turns them into one interrupt line for a host processor. Each source has a status bit that latches when its one-cycle pulse arrives. The bit stays set until software clears it by writing a 1 to that bit position.

Software reads status in two views. The raw view shows every latched event, whether or not it is enabled. The active view shows only the latched events whose enable bit is also set. Enables are changed through a pair of registers: one sets mask bits and the other clears them, so no read-modify-write is needed. A separate output flags that a fatal-class error is latched, whatever the enable mask holds. The fatal class is the fatal error and the tag lookup fatal error.

All access uses a simple register port. A strobe, a write flag, an address and write data go in, and read data comes back combinationally from the addressed register.

Top module: `err_irq_ctrl`

## Requirements
- R1: After reset, all status bits and all enable bits are zero. `err_irq_o` and `fatal_pend_o` are low, and every register reads zero.
- R2: A pulse on `err_evt_i[i]` sets status bit i from the next cycle on. The bit stays set until it is cleared. The source bits are: 0 system error summary, 1 fatal, 2 non-fatal, 3 correctable, 4 tag lookup fatal, 5 end-to-end CRC error.
- R3: A read at offset 0x1C0 returns all latched status bits in bits 5:0, whatever the enables are. A write to 0x1C0 changes nothing.
- R4: A read at offset 0x1C4 returns the status bits ANDed with the enable mask.
- R5: A write to offset 0x1C4 clears each status bit whose write-data bit is 1 and leaves the other status bits unchanged. The clear takes effect at the next cycle.
- R6: If an event pulse and a clear hit the same status bit in the same cycle, the bit ends up set.
- R7: A write to offset 0x1C8 ORs write-data bits 5:0 into the enable mask, so writing 0x3F enables every source. A write to offset 0x1CC clears each enable bit whose write-data bit is 1. Reads at 0x1C8 and 0x1CC both return the enable mask.
- R8: `err_irq_o` is high exactly when at least one status bit is both set and enabled.
- R9: `fatal_pend_o` is high exactly when status bit 1 or status bit 4 is set, whatever the enables are.
- R10: Read data bits 31:6 are always zero, and write-data bits 31:6 are ignored. Addresses other than the four offsets read zero and ignore writes. With `reg_sel_i` low, read data is zero and `reg_wr_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_evt_i | input | 6 | One-cycle error event pulses, one per source |
| reg_sel_i | input | 1 | Register access strobe |
| reg_wr_i | input | 1 | 1 = write, 0 = read (valid when `reg_sel_i` is high) |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the addressed register (combinational) |
| err_irq_o | output | 1 | Error interrupt, high while any enabled status bit is set |
| fatal_pend_o | output | 1 | High while a fatal-class status bit is set |

## Verification
The bench drives an event and a clear on the same bit in one cycle. A design that let the clear win would drop the bit and lose an error. It writes to the raw status offset, to unmapped offsets and with the strobe low, and checks that nothing changes; a decoder that matched too loosely would clear status or change enables. It latches a fatal source while that source is masked, so that a fatal summary wrongly gated by the enables would stay low. It also writes upper data bits to the enable registers, which shows whether a design lets bits above 5 into the mask or the read data. A long mixed sequence then compares read data, the interrupt and the fatal flag with a behavioural model on every cycle.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;

  // Register byte offsets; software decodes these, so they are fixed.
  localparam logic [11:0] OFF_RAW   = 12'h1C0;
  localparam logic [11:0] OFF_ACT   = 12'h1C4;
  localparam logic [11:0] OFF_ENSET = 12'h1C8;
  localparam logic [11:0] OFF_ENCLR = 12'h1CC;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_RAW,
    RSEL_ACT,
    RSEL_ENSET,
    RSEL_ENCLR
  } reg_sel_e;

  // Sticky status bit: an event overrides a clear in the same cycle.
  function automatic logic sticky_bit(input logic cur, input logic clr, input logic evt);
    return evt | (cur & ~clr);
  endfunction

  // Enable bit driven by a set strobe and a clear strobe.
  function automatic logic mask_bit(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/err_status_bank.sv
module err_status_bank #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] raw_q
);
  import err_irq_pkg::*;

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) raw_q[b] <= 1'b0;
      else        raw_q[b] <= sticky_bit(raw_q[b], clr_i[b], evt_i[b]);
    end
  end

endmodule

// File: rtl/err_enable_reg.sv
module err_enable_reg #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] en_q
);
  import err_irq_pkg::*;

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) en_q[b] <= 1'b0;
      else        en_q[b] <= mask_bit(en_q[b], set_i[b], clr_i[b]);
    end
  end

endmodule

// File: rtl/err_reg_decode.sv
module err_reg_decode #(
  parameter int NUM_SRC = 6,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               sel_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] raw_i,
  input  logic [NUM_SRC-1:0] act_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] stat_clr_o,
  output logic [NUM_SRC-1:0] en_set_o,
  output logic [NUM_SRC-1:0] en_clr_o,
  output logic [DATA_W-1:0]  rdata_o
);
  import err_irq_pkg::*;

  reg_sel_e           which;
  logic               wr_go;
  logic [NUM_SRC-1:0] wbits;
  logic               unused_wbits;

  assign wbits        = wdata_i[NUM_SRC-1:0];
  assign unused_wbits = ^wdata_i[DATA_W-1:NUM_SRC];
  assign wr_go        = sel_i & wr_i;

  always_comb begin
    which = RSEL_NONE;
    if (sel_i) begin
      if      (addr_i == ADDR_W'(OFF_RAW))   which = RSEL_RAW;
      else if (addr_i == ADDR_W'(OFF_ACT))   which = RSEL_ACT;
      else if (addr_i == ADDR_W'(OFF_ENSET)) which = RSEL_ENSET;
      else if (addr_i == ADDR_W'(OFF_ENCLR)) which = RSEL_ENCLR;
    end
  end

  assign stat_clr_o = (wr_go && which == RSEL_ACT)   ? wbits : '0;
  assign en_set_o   = (wr_go && which == RSEL_ENSET) ? wbits : '0;
  assign en_clr_o   = (wr_go && which == RSEL_ENCLR) ? wbits : '0;

  always_comb begin
    rdata_o = '0;
    unique case (which)
      RSEL_RAW:               rdata_o = DATA_W'(raw_i);
      RSEL_ACT:               rdata_o = DATA_W'(act_i);
      RSEL_ENSET, RSEL_ENCLR: rdata_o = DATA_W'(en_i);
      default:                rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/err_irq_ctrl.sv
module err_irq_ctrl #(
  parameter int                 NUM_SRC    = 6,
  parameter int                 ADDR_W     = 12,
  parameter int                 DATA_W     = 32,
  parameter logic [NUM_SRC-1:0] FATAL_MASK = 6'b01_0010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] err_evt_i,
  input  logic               reg_sel_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               err_irq_o,
  output logic               fatal_pend_o
);

  // Named internal events, also observed by the checker.
  logic [NUM_SRC-1:0] raw_q;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] act_vec;
  logic [NUM_SRC-1:0] stat_clr;
  logic [NUM_SRC-1:0] en_set;
  logic [NUM_SRC-1:0] en_clr;

  err_reg_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dec_i (
    .sel_i      (reg_sel_i),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .raw_i      (raw_q),
    .act_i      (act_vec),
    .en_i       (en_q),
    .stat_clr_o (stat_clr),
    .en_set_o   (en_set),
    .en_clr_o   (en_clr),
    .rdata_o    (reg_rdata_o)
  );

  err_status_bank #(.NUM_SRC(NUM_SRC)) stat_i (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (err_evt_i),
    .clr_i (stat_clr),
    .raw_q (raw_q)
  );

  err_enable_reg #(.NUM_SRC(NUM_SRC)) en_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (en_set),
    .clr_i (en_clr),
    .en_q  (en_q)
  );

  assign act_vec      = raw_q & en_q;
  assign err_irq_o    = |act_vec;
  assign fatal_pend_o = |(raw_q & FATAL_MASK);

endmodule

// File: rtl/err_irq_ctrl_chk.sv
module err_irq_ctrl_chk #(
  parameter int                 NUM_SRC    = 6,
  parameter int                 ADDR_W     = 12,
  parameter int                 DATA_W     = 32,
  parameter logic [NUM_SRC-1:0] FATAL_MASK = 6'b01_0010
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] err_evt_i,
  input logic               reg_sel_i,
  input logic               reg_wr_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [DATA_W-1:0]  reg_rdata_o,
  input logic               err_irq_o,
  input logic               fatal_pend_o,
  input logic [NUM_SRC-1:0] raw_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] stat_clr
);
  import err_irq_pkg::*;

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & ~stat_clr) != '0) |=>
      ((raw_q & $past(raw_q & ~stat_clr)) == $past(raw_q & ~stat_clr)));

  // R6
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt_i != '0) |=> ((raw_q & $past(err_evt_i)) == $past(err_evt_i)));

  // R3
  raw_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel_i && reg_wr_i && reg_addr_i == ADDR_W'(OFF_RAW) && err_evt_i == '0)
      |=> ($stable(raw_q) && $stable(en_q)));

  // R8
  irq_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq_o |-> ((raw_q & en_q) != '0));

  // R8
  irq_masked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !err_irq_o);

  // R9
  fatal_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_pend_o |-> ((raw_q & FATAL_MASK) != '0));

  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[DATA_W-1:NUM_SRC] == '0);

  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel_i |-> (reg_rdata_o == '0));

endmodule

bind err_irq_ctrl err_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FATAL_MASK(FATAL_MASK)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .err_evt_i    (err_evt_i),
  .reg_sel_i    (reg_sel_i),
  .reg_wr_i     (reg_wr_i),
  .reg_addr_i   (reg_addr_i),
  .reg_rdata_o  (reg_rdata_o),
  .err_irq_o    (err_irq_o),
  .fatal_pend_o (fatal_pend_o),
  .raw_q        (raw_q),
  .en_q         (en_q),
  .stat_clr     (stat_clr)
);

// File: tb/err_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module err_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  evt = '0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        fatal;

  int compared = 0;
  int mismatched = 0;

  // Behavioural reference state
  int unsigned m_raw = 0;
  int unsigned m_en = 0;

  always #2 clk = ~clk;   // 250 MHz

  err_irq_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_evt_i    (evt),
    .reg_sel_i    (sel),
    .reg_wr_i     (wr),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .err_irq_o    (irq),
    .fatal_pend_o (fatal)
  );

  // Reference model update on every edge.
  always @(posedge clk) begin
    int unsigned w;
    int unsigned clr;
    w = wdata & 32'h3F;
    clr = 0;
    if (!rst_n) begin
      m_raw = 0;
      m_en  = 0;
    end else begin
      if (sel && wr) begin
        if (addr == 12'h1C4) clr = w;
        else if (addr == 12'h1C8) m_en = m_en | w;
        else if (addr == 12'h1CC) m_en = m_en & ~w;
      end
      m_raw = (m_raw & ~clr) | evt;
    end
  end

  function automatic int unsigned exp_rdata();
    if (!sel) return 0;
    if (addr == 12'h1C0) return m_raw;
    if (addr == 12'h1C4) return m_raw & m_en;
    if (addr == 12'h1C8 || addr == 12'h1CC) return m_en;
    return 0;
  endfunction

  task automatic compare(input string tag);
    int unsigned er;
    bit ei, ef;
    er = exp_rdata();
    ei = ((m_raw & m_en) != 0);
    ef = ((m_raw & 32'h12) != 0);
    compared += 3;
    if (rdata !== er) begin
      mismatched++;
      $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, addr, rdata, er);
    end
    if (irq !== ei) begin
      mismatched++;
      $display("FAIL %s err_irq actual=%b expected=%b", tag, irq, ei);
    end
    if (fatal !== ef) begin
      mismatched++;
      $display("FAIL %s fatal_pend actual=%b expected=%b", tag, fatal, ef);
    end
  endtask

  // One cycle: drive after falling edge, compare before rising edge.
  task automatic cyc(input logic [5:0] e, input logic s, input logic w,
                     input logic [11:0] a, input logic [31:0] d, input string tag);
    evt = e; sel = s; wr = w; addr = a; wdata = d;
    #1;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    cyc(6'h0, 1'b1, 1'b0, a, 32'h0, tag);
  endtask

  task automatic wrr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(6'h0, 1'b1, 1'b1, a, d, tag);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned lf;
    @(negedge clk);
    // R1: reset state, including during reset
    cyc(6'h3F, 1'b1, 1'b1, 12'h1C8, 32'h3F, "R1 in reset");
    cyc(6'h00, 1'b1, 1'b0, 12'h1C0, 32'h0, "R1 in reset");
    rst_n = 1'b1;
    rd(12'h1C0, "R1 raw");
    rd(12'h1C4, "R1 active");
    rd(12'h1C8, "R1 enset");
    rd(12'h1CC, "R1 enclr");

    // R2, R3, R4: latch a source while masked
    cyc(6'h01, 1'b0, 1'b0, 12'h0, 32'h0, "R2 pulse");
    rd(12'h1C0, "R2 R3 raw sticky");
    rd(12'h1C0, "R2 raw still set");
    rd(12'h1C4, "R4 masked view");

    // R9: fatal while masked
    cyc(6'h02, 1'b0, 1'b0, 12'h0, 32'h0, "R9 pulse");
    rd(12'h1C0, "R9 fatal masked");

    // R7, R8: enable everything
    wrr(12'h1C8, 32'h3F, "R7 enset all");
    rd(12'h1C8, "R7 read enset");
    rd(12'h1CC, "R7 read enclr");
    rd(12'h1C4, "R8 R4 active");

    // R5: clear bit1, then bit0
    wrr(12'h1C4, 32'h02, "R5 clear b1");
    rd(12'h1C0, "R5 R9 after clear");
    wrr(12'h1C4, 32'h01, "R5 clear b0");
    rd(12'h1C0, "R5 R8 all clear");

    // R9: tag lookup fatal source alone
    cyc(6'h10, 1'b0, 1'b0, 12'h0, 32'h0, "R9 b4 pulse");
    rd(12'h1C0, "R9 b4 fatal");

    // R6: event and clear on same bit, same cycle
    cyc(6'h10, 1'b1, 1'b1, 12'h1C4, 32'h10, "R6 collide");
    rd(12'h1C0, "R6 event wins");
    cyc(6'h08, 1'b1, 1'b1, 12'h1C4, 32'h18, "R6 mixed");
    rd(12'h1C0, "R6 R5 mixed result");

    // R7: enable-clear, interrupt drops when nothing enabled
    wrr(12'h1CC, 32'h08, "R7 enclr b3");
    rd(12'h1C4, "R7 R8 active");
    wrr(12'h1CC, 32'h3F, "R7 enclr all");
    rd(12'h1C4, "R8 masked off");

    // R3: writes to raw view are ignored
    wrr(12'h1C0, 32'hFFFF_FFFF, "R3 raw write");
    rd(12'h1C0, "R3 raw unchanged");

    // R10: upper bits, unmapped, strobe low
    wrr(12'h1C8, 32'hFFFF_FFC4, "R10 upper wbits");
    rd(12'h1C8, "R10 upper read zero");
    wrr(12'h1D0, 32'h3F, "R10 unmapped write");
    rd(12'h1D0, "R10 unmapped read");
    rd(12'h1CC, "R10 enable unchanged");
    cyc(6'h00, 1'b0, 1'b1, 12'h1C4, 32'h3F, "R10 sel low");
    rd(12'h1C0, "R10 status unchanged");

    // Mixed sequence against the model
    lf = 32'hACE1_2357;
    for (int i = 0; i < 2000; i++) begin
      logic [11:0] a;
      logic [5:0]  e;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      case (lf[2:0])
        3'd0, 3'd1: a = 12'h1C0;
        3'd2:       a = 12'h1C4;
        3'd3:       a = 12'h1C8;
        3'd4:       a = 12'h1CC;
        3'd5:       a = 12'h1D4;
        default:    a = 12'h004;
      endcase
      e = (lf[11:9] == 3'd0) ? lf[17:12] : 6'h0;
      cyc(e, lf[20], lf[21], a, lf, "R2 R4 R5 R7 R8 R9 mixed");
    end
    finish_run();
  end

endmodule